// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that copies data according to descriptors kept in memory. Software writes the address of the first descriptor and sets the channel enable. It then writes the doorbell. The channel reads the four descriptor words and moves the number of units the descriptor gives. Each unit is one read of the source followed by one write of the target. After each unit the source and target addresses advance by the unit size, each only when its own increment flag is set.

A descriptor can link to another descriptor. The link is an offset from the base address software wrote, not a full pointer. An offset of zero points back at the base, so a set of descriptors can form a ring that runs until software stops it. The channel raises its interrupt only when a descriptor without the link bit completes with its interrupt enable set. A ring therefore never interrupts. An illegal unit-size code, or an error reported by memory, halts the channel and sets the address-error flag.

The register port has four word registers, selected by `reg_addr`:
- 0: descriptor base address.
- 1: status and control.
- 2: live unit count.
- 3: doorbell.

Read data is registered and appears one cycle after the address. Memory accesses use a request/grant handshake. Read data is taken in the cycle the grant is given.

Top module: `ldma_channel`

## Requirements
- R1: After reset the status register (address 1) and the live count (address 2) read 0, `irq` is low and `mem_req` is low.
- R2: A write to the doorbell (address 3) while status bit 0 (enable) is set starts four reads at the base address, +4, +8 and +12. These are taken as command, source address, target address and count word. A doorbell written while enable is clear causes no memory access.
- R3: Bits 23:0 of the count word give the number of units. Each unit is one source read and then one target write of the data read. A count of zero moves nothing and completes the descriptor at once.
- R4: Command bit 23 makes the source address advance after each unit, and command bit 22 does the same for the target address. An address whose bit is clear stays fixed.
- R5: Command bits 10:8 set the address step per unit: code 0 = 4 bytes, 1 = 1, 2 = 2, 3 = 16, 4 = 32, 5 = 64, 6 = 128.
- R6: Unit-size code 7 sets status bit 4 (address error) and bit 2 (halt), clears bit 0, and makes no data access.
- R7: `mem_err` given with a grant sets status bits 4 and 2, clears bit 0, and stops the channel without completing that access.
- R8: With command bit 0 (link) set, the next descriptor is fetched from the base register plus 16 times count-word bits 31:24, once the current descriptor completes.
- R9: A linked descriptor with offset zero returns to the base. The ring repeats without ever setting bit 3 or raising `irq`.
- R10: When a descriptor without the link bit completes, status bit 3 (terminated) sets and bit 0 clears. `irq` rises only if command bit 1 is set. Linked descriptors never raise `irq`.
- R11: A status write sets bit 0 to the written bit 0 and clears bits 2, 3, 4 and `irq`. Writing 0 stops a running channel and withdraws `mem_req`.
- R12: The live count counts down once per completed unit and can be read at address 2. While idle it can be preloaded by writing address 2. A descriptor fetch replaces it.
- R13: Once raised, `mem_req` stays high with a stable address and direction until it is granted, unless software stops the channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 base, 1 status, 2 count, 3 doorbell) |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data for the previous cycle's `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write when high |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Access accepted this cycle |
| mem_err | input | 1 | Address error, valid with `mem_gnt` |
| mem_rdata | input | DW | Read data, valid with `mem_gnt` |
| irq | output | 1 | Chain-complete interrupt, level, cleared by a status write |

## Verification
The assertions assume three things about the environment. Software does not write the status register with bit 0 set while a transfer is in flight. The memory drives `mem_err` only together with `mem_gnt`. The count register is written only while the channel is idle. The bench keeps within these limits. It writes status only before a doorbell, after polling enable low, or with value 0 to stop the ring. Its memory model grants on two of every three cycles and asserts the error only on a granted access at one chosen address.

// File: rtl/ldma_pkg.sv
package ldma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_READ,
    ST_WRITE,
    ST_NEXT
  } ldma_state_e;

  // command word field positions
  localparam int CMD_LINK  = 0;
  localparam int CMD_IRQEN = 1;
  localparam int CMD_USZ   = 8;
  localparam int CMD_TINC  = 22;
  localparam int CMD_SINC  = 23;

  // status word bit positions
  localparam int STB_EN   = 0;
  localparam int STB_HALT = 2;
  localparam int STB_TERM = 3;
  localparam int STB_AERR = 4;

  // register selects
  localparam logic [1:0] RA_BASE = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_CNT  = 2'd2;
  localparam logic [1:0] RA_BELL = 2'd3;

endpackage

// File: rtl/ldma_unit_dec.sv
module ldma_unit_dec #(
  parameter int STEP_W = 8
) (
  input  logic [2:0]        code,
  output logic [STEP_W-1:0] step,
  output logic              bad
);
  always_comb begin
    bad  = 1'b0;
    step = '0;
    case (code)
      3'd0:    step = STEP_W'(4);
      3'd1:    step = STEP_W'(1);
      3'd2:    step = STEP_W'(2);
      3'd3:    step = STEP_W'(16);
      3'd4:    step = STEP_W'(32);
      3'd5:    step = STEP_W'(64);
      3'd6:    step = STEP_W'(128);
      default: bad  = 1'b1;
    endcase
  end
endmodule

// File: rtl/ldma_regs.sv
module ldma_regs
  import ldma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] stat_word,
  input  logic [CW-1:0] live_cnt,
  output logic [DW-1:0] reg_rdata,
  output logic [AW-1:0] desc_base,
  output logic          bell,
  output logic          stat_wr,
  output logic          stat_en,
  output logic          cnt_wr,
  output logic [CW-1:0] cnt_val
);
  assign bell    = reg_we && (reg_addr == RA_BELL);
  assign stat_wr = reg_we && (reg_addr == RA_STAT);
  assign cnt_wr  = reg_we && (reg_addr == RA_CNT);
  assign stat_en = reg_wdata[STB_EN];
  assign cnt_val = reg_wdata[CW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      desc_base <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_we && (reg_addr == RA_BASE)) desc_base <= reg_wdata[AW-1:0];
      case (reg_addr)
        RA_BASE: reg_rdata <= DW'(desc_base);
        RA_STAT: reg_rdata <= stat_word;
        RA_CNT:  reg_rdata <= DW'(live_cnt);
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ldma_engine.sv
module ldma_engine
  import ldma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bell,
  input  logic          stat_wr,
  input  logic          stat_en,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_val,
  input  logic [AW-1:0] desc_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_err,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] stat_word,
  output logic [CW-1:0] live_cnt,
  output logic          irq
);
  localparam int OW         = DW - CW;
  localparam int STEP_W     = 8;
  localparam int WORD_BYTES = DW / 8;
  localparam int LINK_SHIFT = 4;

  ldma_state_e    state_q;
  logic [1:0]     widx_q;
  logic           link_q, irqen_q, sinc_q, tinc_q;
  logic [2:0]     usz_q;
  logic [AW-1:0]  src_q, dst_q;
  logic [OW-1:0]  off_q;
  logic           en_q, halt_q, term_q, aerr_q;

  logic [STEP_W-1:0] step;
  logic              usz_bad;
  logic [AW-1:0]     src_nx, dst_nx, link_addr;
  logic              accept;

  ldma_unit_dec #(.STEP_W(STEP_W)) u_dec (
    .code (usz_q),
    .step (step),
    .bad  (usz_bad)
  );

  assign accept    = mem_req && mem_gnt;
  assign src_nx    = sinc_q ? src_q + AW'(step) : src_q;
  assign dst_nx    = tinc_q ? dst_q + AW'(step) : dst_q;
  assign link_addr = desc_base + (AW'(off_q) << LINK_SHIFT);

  always_comb begin
    stat_word           = '0;
    stat_word[STB_EN]   = en_q;
    stat_word[STB_HALT] = halt_q;
    stat_word[STB_TERM] = term_q;
    stat_word[STB_AERR] = aerr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      widx_q    <= '0;
      link_q    <= 1'b0;
      irqen_q   <= 1'b0;
      sinc_q    <= 1'b0;
      tinc_q    <= 1'b0;
      usz_q     <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      off_q     <= '0;
      live_cnt  <= '0;
      en_q      <= 1'b0;
      halt_q    <= 1'b0;
      term_q    <= 1'b0;
      aerr_q    <= 1'b0;
      irq       <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (stat_wr) begin
      en_q   <= stat_en;
      halt_q <= 1'b0;
      term_q <= 1'b0;
      aerr_q <= 1'b0;
      irq    <= 1'b0;
      if (!stat_en) begin
        state_q <= ST_IDLE;
        mem_req <= 1'b0;
        mem_we  <= 1'b0;
      end
    end else begin
      if (cnt_wr && state_q == ST_IDLE) live_cnt <= cnt_val;
      case (state_q)
        ST_IDLE: begin
          if (bell && en_q) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= desc_base;
            widx_q   <= '0;
            state_q  <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (accept) begin
            if (mem_err) begin
              aerr_q <= 1'b1; halt_q <= 1'b1; en_q <= 1'b0;
              mem_req <= 1'b0; mem_we <= 1'b0; state_q <= ST_IDLE;
            end else begin
              case (widx_q)
                2'd0: begin
                  link_q  <= mem_rdata[CMD_LINK];
                  irqen_q <= mem_rdata[CMD_IRQEN];
                  usz_q   <= mem_rdata[CMD_USZ +: 3];
                  tinc_q  <= mem_rdata[CMD_TINC];
                  sinc_q  <= mem_rdata[CMD_SINC];
                end
                2'd1: src_q <= mem_rdata[AW-1:0];
                2'd2: dst_q <= mem_rdata[AW-1:0];
                default: begin
                  live_cnt <= mem_rdata[CW-1:0];
                  off_q    <= mem_rdata[DW-1:CW];
                end
              endcase
              if (widx_q == 2'd3) begin
                mem_req <= 1'b0;
                state_q <= ST_DECODE;
              end else begin
                widx_q   <= widx_q + 2'd1;
                mem_addr <= mem_addr + AW'(WORD_BYTES);
              end
            end
          end
        end
        ST_DECODE: begin
          if (usz_bad) begin
            aerr_q <= 1'b1; halt_q <= 1'b1; en_q <= 1'b0;
            mem_req <= 1'b0; mem_we <= 1'b0; state_q <= ST_IDLE;
          end else if (live_cnt == '0) begin
            state_q <= ST_NEXT;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= src_q;
            state_q  <= ST_READ;
          end
        end
        ST_READ: begin
          if (accept) begin
            if (mem_err) begin
              aerr_q <= 1'b1; halt_q <= 1'b1; en_q <= 1'b0;
              mem_req <= 1'b0; mem_we <= 1'b0; state_q <= ST_IDLE;
            end else begin
              mem_we    <= 1'b1;
              mem_addr  <= dst_q;
              mem_wdata <= mem_rdata;
              state_q   <= ST_WRITE;
            end
          end
        end
        ST_WRITE: begin
          if (accept) begin
            if (mem_err) begin
              aerr_q <= 1'b1; halt_q <= 1'b1; en_q <= 1'b0;
              mem_req <= 1'b0; mem_we <= 1'b0; state_q <= ST_IDLE;
            end else begin
              live_cnt <= live_cnt - CW'(1);
              src_q    <= src_nx;
              dst_q    <= dst_nx;
              mem_we   <= 1'b0;
              if (live_cnt == CW'(1)) begin
                mem_req <= 1'b0;
                state_q <= ST_NEXT;
              end else begin
                mem_addr <= src_nx;
                state_q  <= ST_READ;
              end
            end
          end
        end
        ST_NEXT: begin
          if (link_q) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= link_addr;
            widx_q   <= '0;
            state_q  <= ST_FETCH;
          end else begin
            term_q  <= 1'b1;
            en_q    <= 1'b0;
            irq     <= irq | irqen_q;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldma_channel.sv
module ldma_channel #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_err,
  input  logic [DW-1:0] mem_rdata,
  output logic          irq
);
  logic [DW-1:0] stat_word;
  logic [CW-1:0] live_cnt;
  logic [AW-1:0] desc_base;
  logic          bell, stat_wr, stat_en, cnt_wr;
  logic [CW-1:0] cnt_val;

  ldma_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .stat_word (stat_word),
    .live_cnt  (live_cnt),
    .reg_rdata (reg_rdata),
    .desc_base (desc_base),
    .bell      (bell),
    .stat_wr   (stat_wr),
    .stat_en   (stat_en),
    .cnt_wr    (cnt_wr),
    .cnt_val   (cnt_val)
  );

  ldma_engine #(.AW(AW), .DW(DW), .CW(CW)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .bell      (bell),
    .stat_wr   (stat_wr),
    .stat_en   (stat_en),
    .cnt_wr    (cnt_wr),
    .cnt_val   (cnt_val),
    .desc_base (desc_base),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt),
    .mem_err   (mem_err),
    .mem_rdata (mem_rdata),
    .stat_word (stat_word),
    .live_cnt  (live_cnt),
    .irq       (irq)
  );
endmodule

// File: rtl/ldma_channel_chk.sv
module ldma_channel_chk #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_we,
  input logic [1:0]    reg_addr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_gnt,
  input logic          mem_err,
  input logic          irq,
  input logic          en_bit,
  input logic          term_bit,
  input logic [CW-1:0] live_cnt
);
  logic stat_write;
  assign stat_write = reg_we && (reg_addr == 2'd1);

  // R13: an ungranted request is held unchanged
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt && !stat_write) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R12: each completed write takes one unit off the live count
  assert_count_step_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_gnt && !mem_err && !stat_write) |=>
      (live_cnt == $past(live_cnt) - CW'(1)));

  // R10: the interrupt rises only together with the terminated flag
  assert_irq_on_term_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> term_bit);

  // R10: termination leaves no access outstanding
  assert_term_idle_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(term_bit) |-> (!mem_req && !en_bit));

  // R11: memory is only requested by an enabled channel
  assert_req_needs_en_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> en_bit);
endmodule

bind ldma_channel ldma_channel_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_gnt  (mem_gnt),
  .mem_err  (mem_err),
  .irq      (irq),
  .en_bit   (stat_word[0]),
  .term_bit (stat_word[3]),
  .live_cnt (live_cnt)
);

// File: tb/ldma_channel_test.sv
module ldma_channel_test;
  localparam logic [31:0] SINC = 32'h0080_0000;
  localparam logic [31:0] TINC = 32'h0040_0000;
  localparam logic [31:0] IE   = 32'h0000_0002;
  localparam logic [31:0] LNK  = 32'h0000_0001;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_gnt, mem_err, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  ldma_channel uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_err(mem_err), .mem_rdata(mem_rdata), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] mem [0:255];
  logic [31:0] rd_log [0:15];
  int wr_cnt, rd_cnt, base_rd, early_irq, gcnt;
  logic [31:0] last_wa;
  logic err_on;
  logic [31:0] err_addr;

  // memory model: grants two of every three cycles
  initial begin
    mem_gnt = 0; mem_err = 0; mem_rdata = 0; gcnt = 0;
    forever begin
      @(negedge clk);
      gcnt++;
      if (irq && wr_cnt < 3) early_irq++;
      if (mem_req && (gcnt % 3 != 0)) begin
        mem_gnt = 1;
        if (err_on && mem_addr == err_addr) mem_err = 1;
        else begin
          mem_err = 0;
          if (mem_we) begin
            mem[mem_addr[9:2]] = mem_wdata;
            wr_cnt++;
            last_wa = mem_addr;
          end else begin
            mem_rdata = mem[mem_addr[9:2]];
            if (rd_cnt < 16) rd_log[rd_cnt] = mem_addr;
            rd_cnt++;
            if (mem_addr == 32'h40) base_rd++;
          end
        end
      end else begin
        mem_gnt = 0; mem_err = 0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rwr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rrd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    bit done = 0;
    for (int n = 0; n < 3000 && !done; n++) begin
      rrd(2'd1, s);
      if (!s[0]) done = 1;
    end
    chk("R10 channel reaches idle", {31'd0, done}, 32'd1);
  endtask

  task automatic init_mem();
    for (int i = 0; i < 256; i++)
      mem[i] = (i >= 64 && i < 128) ? 32'hA500_0000 + i : 32'h0;
  endtask

  task automatic put_desc(input int a, input logic [31:0] cmd, src, dst, cw);
    mem[(a >> 2) + 0] = cmd;
    mem[(a >> 2) + 1] = src;
    mem[(a >> 2) + 2] = dst;
    mem[(a >> 2) + 3] = cw;
  endtask

  task automatic run(input logic [31:0] base);
    rwr(2'd1, 32'd1);
    rwr(2'd0, base);
    wr_cnt = 0; rd_cnt = 0; early_irq = 0; base_rd = 0;
    rwr(2'd3, 32'd0);
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] s, c;
    int sz, tot;
    rst = 1; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    wr_cnt = 0; rd_cnt = 0; base_rd = 0; early_irq = 0; last_wa = 0;
    err_on = 0; err_addr = 0;
    init_mem();
    repeat (5) @(negedge clk);
    rst = 0;

    // R1 reset state
    rrd(2'd1, s); chk("R1 status", s, 32'd0);
    rrd(2'd2, s); chk("R1 count", s, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);

    // R2 doorbell ignored while disabled
    put_desc(0, SINC | TINC | IE, 32'h100, 32'h200, 32'd1);
    rwr(2'd0, 32'd0);
    rd_cnt = 0;
    rwr(2'd3, 32'd0);
    repeat (20) @(negedge clk);
    chk("R2 no access when disabled", rd_cnt, 0);
    rrd(2'd1, s); chk("R2 status untouched", s, 32'd0);

    // R2 R3 R4 R10 basic copy of five units
    init_mem();
    put_desc(0, SINC | TINC | IE, 32'h100, 32'h200, 32'd5);
    run(32'h0);
    for (int k = 0; k < 4; k++) chk("R2 fetch order", rd_log[k], 32'(4 * k));
    for (int k = 0; k < 5; k++) chk("R3 copied word", mem[128 + k], mem[64 + k]);
    chk("R3 nothing past count", mem[133], 32'd0);
    chk("R3 write count", wr_cnt, 5);
    rrd(2'd1, s); chk("R10 terminated status", s, 32'h8);
    chk("R10 irq raised", {31'd0, irq}, 32'd1);
    rwr(2'd1, 32'd1);
    rrd(2'd1, s); chk("R11 status write clears flags", s, 32'h1);
    chk("R11 irq cleared", {31'd0, irq}, 32'd0);

    // R4 fixed source
    init_mem();
    put_desc(0, TINC | IE, 32'h100, 32'h200, 32'd3);
    run(32'h0);
    for (int k = 0; k < 3; k++) chk("R4 fixed source", mem[128 + k], mem[64]);

    // R4 fixed target
    init_mem();
    put_desc(0, SINC | IE, 32'h100, 32'h200, 32'd3);
    run(32'h0);
    chk("R4 fixed target last value", mem[128], mem[66]);
    chk("R4 fixed target no spill", mem[129], 32'd0);

    // R5 unit size sweep
    for (int code = 0; code < 7; code++) begin
      sz = (code == 0) ? 4 : (code < 3 ? code : (1 << (code + 1)));
      init_mem();
      put_desc(0, SINC | TINC | IE | (32'(code) << 8), 32'h100, 32'h200, 32'd2);
      run(32'h0);
      chk("R5 two units", wr_cnt, 2);
      chk("R5 second target address", last_wa, 32'h200 + 32'(sz));
      chk("R5 second unit data", mem[(32'h200 + sz) >> 2], mem[(32'h100 + sz) >> 2]);
    end

    // R6 illegal unit size
    init_mem();
    put_desc(0, SINC | TINC | IE | (32'd7 << 8), 32'h100, 32'h200, 32'd2);
    run(32'h0);
    rrd(2'd1, s); chk("R6 error status", s, 32'h14);
    chk("R6 no data writes", wr_cnt, 0);
    chk("R6 only descriptor reads", rd_cnt, 4);
    chk("R6 no irq", {31'd0, irq}, 32'd0);

    // R7 memory error on the second source read
    init_mem();
    err_on = 1; err_addr = 32'h104;
    put_desc(0, SINC | TINC | IE, 32'h100, 32'h200, 32'd3);
    run(32'h0);
    err_on = 0;
    rrd(2'd1, s); chk("R7 error status", s, 32'h14);
    chk("R7 one unit done", wr_cnt, 1);
    rrd(2'd2, s); chk("R12 count left after error", s, 32'd2);

    // R8 chain of three, offsets relative to the base
    init_mem();
    put_desc(32'h00, LNK | SINC | TINC, 32'h100, 32'h200, (32'd2 << 24) | 32'd1);
    put_desc(32'h20, LNK | SINC | TINC, 32'h104, 32'h204, (32'd1 << 24) | 32'd1);
    put_desc(32'h10, SINC | TINC | IE, 32'h108, 32'h208, 32'd1);
    run(32'h0);
    chk("R8 second descriptor address", rd_log[5], 32'h20);
    chk("R8 third descriptor address", rd_log[10], 32'h10);
    for (int k = 0; k < 3; k++) chk("R8 chained copy", mem[128 + k], mem[64 + k]);
    chk("R10 no irq mid chain", early_irq, 0);
    chk("R10 irq at chain end", {31'd0, irq}, 32'd1);

    // R10 completion without interrupt enable
    init_mem();
    put_desc(0, SINC | TINC, 32'h100, 32'h200, 32'd2);
    run(32'h0);
    rrd(2'd1, s); chk("R10 terminated without irq enable", s, 32'h8);
    chk("R10 irq stays low", {31'd0, irq}, 32'd0);

    // R9 ring, then R11 stop
    init_mem();
    put_desc(32'h40, LNK | SINC | TINC | IE, 32'h100, 32'h200, 32'd2);
    rwr(2'd1, 32'd1);
    rwr(2'd0, 32'h40);
    wr_cnt = 0; rd_cnt = 0; base_rd = 0;
    rwr(2'd3, 32'd0);
    repeat (300) @(negedge clk);
    rrd(2'd1, s); chk("R9 ring still running", s, 32'h1);
    chk("R9 ring never interrupts", {31'd0, irq}, 32'd0);
    chk("R9 ring refetches base", {31'd0, base_rd >= 3}, 32'd1);
    rrd(2'd2, c); chk("R12 live count in range", {31'd0, c <= 2}, 32'd1);
    rwr(2'd1, 32'd0);
    repeat (4) @(negedge clk);
    rrd(2'd1, s); chk("R11 stopped status", s, 32'd0);
    chk("R11 request withdrawn", {31'd0, mem_req}, 32'd0);
    tot = rd_cnt + wr_cnt;
    repeat (20) @(negedge clk);
    chk("R11 no access after stop", rd_cnt + wr_cnt, tot);

    // R12 preload and R3 zero count
    rwr(2'd2, 32'h123);
    rrd(2'd2, s); chk("R12 preload readback", s, 32'h123);
    init_mem();
    put_desc(0, SINC | TINC | IE, 32'h100, 32'h200, 32'd0);
    run(32'h0);
    rrd(2'd1, s); chk("R3 zero count terminates", s, 32'h8);
    chk("R3 zero count moves nothing", wr_cnt, 0);
    rrd(2'd2, s); chk("R12 fetch replaces preload", s, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule